// File: doc/BRIEF.md
# Three-Port Non-Blocking Crossbar Switch

This block connects three input ports to three output ports over 8-bit data paths. A source chooses an output by placing a 2-bit destination number on its port, then raises its request line. When that output has no current owner, the switch returns a grant and forwards the source's data bytes to the output for as long as the request stays high. Lowering the request releases the output so that another source can claim it.

Every output port has its own round-robin arbiter. When several sources ask for the same free output in the same cycle, one of them is chosen and the others keep their grants low and wait. Connections that use different outputs do not affect each other, so three disjoint paths can carry data at the same time. All outputs are registered, and the whole block runs on one clock with a synchronous active-high reset.

Top module: `nb_crossbar`

## Requirements
- R1: After reset, all grants are low, all output valid flags are low, all output data is zero, and each output's arbiter gives input 0 the highest priority.
- R2: At most one input is connected to an output at any time. A request for an output that another input holds leaves the requester's grant low until the output is released.
- R3: A destination value of 3 (binary 11) is invalid. A request that carries it is never granted.
- R4: While input i is connected and its request is high in cycle t, output port d (d is the binary value of the latched destination) carries input i's data byte in cycle t+1, with its valid flag high.
- R5: If a connected input lowers its request in cycle t, then from cycle t+1 its grant is low and the output's valid flag is low, and the output can be arbitrated again in cycle t+1.
- R6: Connections to distinct outputs can coexist. Up to three inputs can be connected and forwarding data at once.
- R7: Among inputs that request the same free output in the same cycle, the winner is the first requester found by counting upward (with wrap-around) from the input after that output's previous winner. The inputs that lose keep their grants low.
- R8: The destination is captured when the grant is given. Changes to the destination input during a connection have no effect on routing until the connection is released.
- R9: An output with no active connection drives zero data with its valid flag low.
- R10: An unconnected input whose request is high in cycle t, for a free output with no rival request, sees its grant high from cycle t+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 24 | Input data, byte i at bits [8i+7:8i] |
| in_req | input | 3 | Request per input, held high for the whole transfer |
| in_dest | input | 6 | Destination output per input, 2 bits each at [2i+1:2i] |
| in_gnt | output | 3 | Grant per input, registered |
| out_data | output | 24 | Output data, byte d at bits [8d+7:8d] |
| out_vld | output | 3 | Output valid per output port |

## Verification
The assertions assume that a source sets its destination no later than the cycle in which it raises its request, and that it changes the destination only when it is not connected or when the change is meant to be ignored. The stimulus keeps to this. Each scenario sets a destination and a request together on a falling edge. Destinations change under a held grant only in the scenario that checks they are ignored, and the invalid destination value is driven only in its own scenario. Input data changes every cycle, so any routing error shows up as a byte mismatch.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Next index in a ring of n entries
  function automatic int ring_next(input int cur, input int n);
    return (cur >= n - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
  import xbar_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          gnt_any,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    int idx;
    gnt     = '0;
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!gnt_any && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_any  = 1'b1;
        gnt_idx  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (gnt_any) ptr_q <= IW'(ring_next(int'(gnt_idx), N));
  end

  p_gnt_single_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  p_gnt_needs_req_r7: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
endmodule

// File: rtl/xbar_in_ctl.sv
module xbar_in_ctl #(
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic           win,
  input  logic [IDW-1:0] win_dest,
  output logic           conn,
  output logic [IDW-1:0] dest_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      conn   <= 1'b0;
      dest_q <= '0;
    end else if (conn && !req) begin
      conn <= 1'b0;
    end else if (win) begin
      conn   <= 1'b1;
      dest_q <= win_dest;
    end
  end

  p_release_r5: assert property (@(posedge clk) disable iff (rst) conn && !req |=> !conn);
  p_dest_hold_r8: assert property (@(posedge clk) disable iff (rst) conn && req |=> $stable(dest_q));
endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N*DW-1:0] in_data,
  input  logic [N-1:0]  in_req,
  input  logic          gnt_any,
  input  logic [IW-1:0] gnt_idx,
  output logic          busy,
  output logic [DW-1:0] out_data,
  output logic          out_vld
);
  logic [IW-1:0] own_q;
  logic          live;
  logic [DW-1:0] sel_data;

  assign live     = busy && in_req[own_q];
  assign sel_data = in_data[int'(own_q)*DW +: DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      own_q <= '0;
    end else if (busy && !in_req[own_q]) begin
      busy <= 1'b0;
    end else if (gnt_any) begin
      busy  <= 1'b1;
      own_q <= gnt_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld  <= live;
      out_data <= live ? sel_data : '0;
    end
  end

  p_route_r4: assert property (@(posedge clk) disable iff (rst)
    live |=> out_vld && out_data == $past(sel_data));
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> out_data == '0);
  p_no_steal_r2: assert property (@(posedge clk) disable iff (rst)
    busy && in_req[own_q] |=> busy && $stable(own_q));
endmodule

// File: rtl/nb_crossbar.sv
module nb_crossbar #(
  parameter int NPORT = 3,
  parameter int DW    = 8,
  parameter int IDW   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT*DW-1:0] in_data,
  input  logic [NPORT-1:0]    in_req,
  input  logic [NPORT*IDW-1:0] in_dest,
  output logic [NPORT-1:0]    in_gnt,
  output logic [NPORT*DW-1:0] out_data,
  output logic [NPORT-1:0]    out_vld
);
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NPORT-1:0] conn;
  logic [IDW-1:0]   dest_q [NPORT];
  logic [NPORT-1:0] busy;
  logic [NPORT-1:0] arb_req [NPORT];
  logic [NPORT-1:0] arb_gnt [NPORT];
  logic [NPORT-1:0] arb_any;
  logic [IW-1:0]    arb_idx [NPORT];
  logic [NPORT-1:0] win;

  always_comb begin
    win = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        win[i] = win[i] | arb_gnt[o][i];
  end

  assign in_gnt = conn;

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    for (genvar i = 0; i < NPORT; i++) begin : g_req
      assign arb_req[o][i] = in_req[i] && !conn[i] && !busy[o] &&
                             (in_dest[i*IDW +: IDW] == IDW'(o));
    end

    xbar_rr_arb #(.N(NPORT), .IW(IW)) u_arb (
      .clk(clk), .rst(rst), .req(arb_req[o]), .gnt(arb_gnt[o]),
      .gnt_any(arb_any[o]), .gnt_idx(arb_idx[o])
    );

    xbar_out_port #(.N(NPORT), .DW(DW), .IW(IW)) u_port (
      .clk(clk), .rst(rst), .in_data(in_data), .in_req(in_req),
      .gnt_any(arb_any[o]), .gnt_idx(arb_idx[o]), .busy(busy[o]),
      .out_data(out_data[o*DW +: DW]), .out_vld(out_vld[o])
    );

    logic [NPORT-1:0] held_by;
    for (genvar i = 0; i < NPORT; i++) begin : g_held
      assign held_by[i] = conn[i] && (dest_q[i] == IDW'(o));
    end
    p_one_owner_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(held_by));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    xbar_in_ctl #(.IDW(IDW)) u_ctl (
      .clk(clk), .rst(rst), .req(in_req[i]), .win(win[i]),
      .win_dest(in_dest[i*IDW +: IDW]), .conn(conn[i]), .dest_q(dest_q[i])
    );

    p_bad_dest_r3: assert property (@(posedge clk) disable iff (rst)
      in_req[i] && int'(in_dest[i*IDW +: IDW]) >= NPORT && !in_gnt[i] |=> !in_gnt[i]);
  end
endmodule

// File: tb/tb_nb_crossbar.sv
module tb_nb_crossbar;
  localparam int N = 3;
  localparam int DW = 8;
  localparam int EW = N + N + N*DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    in_req = '0;
  logic [N*2-1:0]  in_dest = '0;
  logic [N-1:0]    in_gnt;
  logic [N*DW-1:0] out_data;
  logic [N-1:0]    out_vld;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  string cur_tag = "R1";
  logic [EW-1:0] sb_q[$];

  always #2.5 clk = ~clk;

  nb_crossbar dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_req(in_req),
    .in_dest(in_dest), .in_gnt(in_gnt), .out_data(out_data), .out_vld(out_vld)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < N; i++) in_data[i*DW +: DW] <= 8'(cyc*13 + i*71 + 5);
  end

  // Reference model of the requirements; pushes expected results per edge
  bit m_conn[N];
  int m_dest[N];
  bit m_busy[N];
  int m_own[N];
  int m_ptr[N];

  always @(posedge clk) begin
    logic [N-1:0] e_gnt, e_vld;
    logic [N*DW-1:0] e_data;
    bit n_conn[N];
    int n_dest[N];
    bit n_busy[N];
    int n_own[N];
    int n_ptr[N];
    e_gnt = '0; e_vld = '0; e_data = '0;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_conn[i] = 0; m_dest[i] = 0; m_busy[i] = 0; m_own[i] = 0; m_ptr[i] = 0;
      end
    end else begin
      for (int o = 0; o < N; o++) begin
        if (m_busy[o] && in_req[m_own[o]]) begin
          e_vld[o] = 1'b1;
          e_data[o*DW +: DW] = in_data[m_own[o]*DW +: DW];
        end
      end
      for (int i = 0; i < N; i++) begin
        n_conn[i] = m_conn[i]; n_dest[i] = m_dest[i];
        n_busy[i] = m_busy[i]; n_own[i] = m_own[i]; n_ptr[i] = m_ptr[i];
      end
      for (int i = 0; i < N; i++)
        if (m_conn[i] && !in_req[i]) begin
          n_conn[i] = 0;
          n_busy[m_dest[i]] = 0;
        end
      for (int o = 0; o < N; o++) begin
        if (!m_busy[o]) begin
          bit done;
          done = 0;
          for (int k = 0; k < N; k++) begin
            int i;
            i = (m_ptr[o] + k) % N;
            if (!done && in_req[i] && !m_conn[i] && int'(in_dest[i*2 +: 2]) == o) begin
              done = 1;
              n_conn[i] = 1; n_dest[i] = o;
              n_busy[o] = 1; n_own[o] = i; n_ptr[o] = (i + 1) % N;
            end
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        m_conn[i] = n_conn[i]; m_dest[i] = n_dest[i];
        m_busy[i] = n_busy[i]; m_own[i] = n_own[i]; m_ptr[i] = n_ptr[i];
        e_gnt[i] = n_conn[i];
      end
    end
    sb_q.push_back({e_gnt, e_vld, e_data});
  end

  // Monitor: compare registered outputs away from the rising edge
  always @(negedge clk) begin
    logic [EW-1:0] e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      for (int p = 0; p < N; p++) begin
        checks++;
        if (in_gnt[p] !== e[EW-1-(N-1-p)]) begin
          errs++;
          $display("FAIL %s grant[%0d] cycle %0d: got %b exp %b", cur_tag, p, cyc,
                   in_gnt[p], e[EW-1-(N-1-p)]);
        end
        checks++;
        if (out_vld[p] !== e[N*DW + p] || out_data[p*DW +: DW] !== e[p*DW +: DW]) begin
          errs++;
          $display("FAIL %s out[%0d] cycle %0d: got vld=%b data=%h exp vld=%b data=%h",
                   cur_tag, p, cyc, out_vld[p], out_data[p*DW +: DW],
                   e[N*DW + p], e[p*DW +: DW]);
        end
      end
    end
  end

  task automatic setp(input int i, input bit r, input int d);
    in_req[i] = r;
    in_dest[i*2 +: 2] = 2'(d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic direct(input string tag, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s direct check cycle %0d: got %b exp %b", tag, cyc, got, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired: got running exp finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cur_tag = "R1";
    idle(4);
    @(negedge clk) rst = 1'b0;
    idle(2);
    direct("R1", out_vld == '0 && in_gnt == '0, 1'b1);

    cur_tag = "R10";
    setp(0, 1, 1);
    idle(1);
    direct("R10", in_gnt[0], 1'b1);
    cur_tag = "R4";
    idle(5);
    cur_tag = "R8";
    setp(0, 1, 2);
    idle(4);
    direct("R8", out_vld[1], 1'b1);
    cur_tag = "R5";
    setp(0, 0, 2);
    idle(1);
    direct("R5", in_gnt[0], 1'b0);
    cur_tag = "R9";
    idle(3);

    cur_tag = "R6";
    setp(0, 1, 2); setp(1, 1, 0); setp(2, 1, 1);
    idle(6);
    direct("R6", &out_vld, 1'b1);
    setp(0, 0, 0); setp(1, 0, 0); setp(2, 0, 0);
    idle(3);

    cur_tag = "R7";
    setp(0, 1, 0); setp(1, 1, 0); setp(2, 1, 0);
    idle(4);
    setp(0, 0, 0);
    idle(4);
    setp(1, 0, 0);
    idle(4);
    setp(2, 0, 0);
    idle(2);
    setp(0, 1, 0); setp(1, 1, 0); setp(2, 1, 0);
    idle(3);
    setp(0, 0, 0); setp(1, 0, 0); setp(2, 0, 0);
    idle(3);

    cur_tag = "R2";
    setp(2, 1, 1);
    idle(2);
    setp(0, 1, 1);
    idle(4);
    direct("R2", in_gnt[0], 1'b0);
    setp(2, 0, 1);
    idle(4);
    setp(0, 0, 0);
    idle(3);

    cur_tag = "R3";
    setp(1, 1, 3);
    idle(5);
    direct("R3", in_gnt[1], 1'b0);
    setp(1, 0, 0);
    idle(2);

    cur_tag = "R9";
    idle(4);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule